// File: doc/BRIEF.md
# Rewindable Endpoint Transmit Buffer

This block holds outgoing packet bytes for one device endpoint. Firmware pushes bytes through a write port, and the serial engine pulls them through a read port. Besides the read pointer, the block keeps a packet-start marker. When a packet is delivered, the marker moves forward to release its bytes. When it is not delivered, the read pointer moves back so the engine can send the same bytes again.

An 8-bit control register chooses the capacity, isochronous operation, automatic or manual marker handling, and a self-clearing flush. The engine reports each packet outcome on a result input. The block outputs the occupied byte count, the bytes still unread, empty and full flags, the last handshake outcome, an underrun flag and the data-toggle bit.

Top module: `txpkt_buf`

## Requirements
- R1: After reset, the control register reads 0x04. Byte count and readable count are 0, empty is 1, full is 0, and all status outputs are 0.
- R2: With the isochronous bit (bit 3) clear and `feat_en` high, the size field (bits 6:5) values 0, 1, 2 and 3 give capacities of 16, 64, 8 and 32 bytes. Full rises when the byte count equals the capacity. Writes while full are dropped.
- R3: With `feat_en` low and the isochronous bit clear, size values 2 and 3 give 64 bytes instead of 8 and 32.
- R4: With the isochronous bit set, size values 0, 1, 2 and 3 give 64, 256, 512 and 1024 bytes.
- R5: In automatic mode (bit 2 set), a non-isochronous result of ACK (`eop_result`=01) moves the marker to the read pointer. The byte count drops to the unread count, `stat_ack` goes to 1, `stat_err` goes to 0, and `data_seq` toggles.
- R6: In automatic mode, a non-isochronous result other than ACK (10 for NACK, 00 or 11 for no handshake) moves the read pointer back to the marker. The same bytes are then read out again, the byte count is unchanged, `stat_err` goes to 1 and `stat_ack` goes to 0.
- R7: With the isochronous bit set, every result commits the packet regardless of its code. `data_seq`, `stat_ack` and `stat_err` are left unchanged.
- R8: Writing bit 7 set flushes the buffer on the next clock edge. Pointers, marker and counts go to zero, empty goes to 1, and `stat_ack`, `stat_err` and `stat_underrun` clear. `data_seq` keeps its value. Bit 7 reads 1 for exactly one cycle and then reads 0.
- R9: With automatic mode off, writing bit 1 alone (bit 0 clear) moves the marker to the read pointer on the next edge. The bit then reads 0.
- R10: With automatic mode off, writing bit 0 alone (bit 1 clear) moves the read pointer back to the marker on the next edge. The bit then reads 0.
- R11: Bits 1 and 0 move nothing when automatic mode is on or when both are written together. Either way they read 0 afterwards.
- R12: Bit 4 always reads 0. Writing the isochronous bit set also forces the automatic bit to 1.
- R13: A read with no unread byte leaves `rd_data` at its previous value and sets `stat_underrun`. A flush clears `stat_underrun`.
- R14: With automatic mode off and the isochronous bit clear, a result moves neither the marker nor the read pointer, but it still updates `stat_ack`, `stat_err` and `data_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Enables the 8- and 32-byte non-isochronous sizes |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value |
| wr_en | input | 1 | Firmware byte push |
| wr_data | input | DATA_W | Byte to push |
| rd_en | input | 1 | Engine byte pull |
| rd_data | output | DATA_W | Last byte pulled (registered) |
| eop_valid | input | 1 | Packet outcome strobe |
| eop_result | input | 2 | 01 ACK, 10 NACK, 00/11 no handshake |
| byte_count | output | PTR_W+1 | Bytes held from the marker to the write pointer |
| rd_avail | output | PTR_W+1 | Bytes not yet pulled |
| empty | output | 1 | Byte count is zero |
| full | output | 1 | Byte count equals capacity |
| stat_ack | output | 1 | Last non-isochronous outcome was ACK |
| stat_err | output | 1 | Last non-isochronous outcome was not ACK |
| stat_underrun | output | 1 | A pull found nothing to read |
| data_seq | output | 1 | Data-toggle bit |

## Verification
The bench builds the block with its default parameters, 8-bit data and a 1024-byte store. That store is large enough to reach every capacity, including the 1024-byte isochronous setting, so each of the eight size codes can be filled to full and overfilled. The default widths also let the full-pointer wrap and the count at exact capacity be observed without truncation.

// File: rtl/txpkt_buf.sv
module txpkt_buf #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 1024,
  parameter int PTR_W     = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eop_valid,
  input  logic [1:0]        eop_result,
  output logic [PTR_W:0]    byte_count,
  output logic [PTR_W:0]    rd_avail,
  output logic              empty,
  output logic              full,
  output logic              stat_ack,
  output logic              stat_err,
  output logic              stat_underrun,
  output logic              data_seq
);

  localparam logic [1:0] RES_ACK = 2'b01;

  logic       ctl_clr, ctl_iso, ctl_atm, ctl_adv, ctl_rev;
  logic [1:0] ctl_size;

  logic [PTR_W:0] wptr, rptr, rmark;
  logic [PTR_W:0] cap, mask;
  int unsigned    cap_raw;

  logic [DATA_W-1:0] mem [MAX_DEPTH];

  always_comb begin
    if (ctl_iso) begin
      case (ctl_size)
        2'd0:    cap_raw = 64;
        2'd1:    cap_raw = 256;
        2'd2:    cap_raw = 512;
        default: cap_raw = 1024;
      endcase
    end else begin
      case (ctl_size)
        2'd0:    cap_raw = 16;
        2'd1:    cap_raw = 64;
        2'd2:    cap_raw = feat_en ? 8 : 64;
        default: cap_raw = feat_en ? 32 : 64;
      endcase
    end
    if (cap_raw > MAX_DEPTH) cap_raw = MAX_DEPTH;
  end

  assign cap  = (PTR_W+1)'(cap_raw);
  assign mask = cap - 1'b1;

  assign byte_count = wptr - rmark;
  assign rd_avail   = wptr - rptr;
  assign empty      = (byte_count == '0);
  assign full       = (byte_count >= cap);
  assign ctl_rdata  = {ctl_clr, ctl_size, 1'b0, ctl_iso, ctl_atm, ctl_adv, ctl_rev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_clr  <= 1'b0;
      ctl_size <= 2'b00;
      ctl_iso  <= 1'b0;
      ctl_atm  <= 1'b1;
      ctl_adv  <= 1'b0;
      ctl_rev  <= 1'b0;
    end else if (ctl_we) begin
      ctl_clr  <= ctl_wdata[7];
      ctl_size <= ctl_wdata[6:5];
      ctl_iso  <= ctl_wdata[3];
      ctl_atm  <= ctl_wdata[2] | ctl_wdata[3];
      ctl_adv  <= ctl_wdata[1];
      ctl_rev  <= ctl_wdata[0];
    end else begin
      ctl_clr <= 1'b0;
      ctl_adv <= 1'b0;
      ctl_rev <= 1'b0;
    end
  end

  logic eop_ok, is_ack, do_adv, do_rev, commit, rewind;
  logic wr_ok, rd_try, rd_ok;

  assign eop_ok = eop_valid & ~ctl_clr;
  assign is_ack = (eop_result == RES_ACK);
  assign do_adv = ctl_adv & ~ctl_atm & ~ctl_rev & ~ctl_clr;
  assign do_rev = ctl_rev & ~ctl_atm & ~ctl_adv & ~ctl_clr;
  assign commit = (eop_ok & ctl_iso) | (eop_ok & ~ctl_iso & ctl_atm & is_ack) | do_adv;
  assign rewind = (eop_ok & ~ctl_iso & ctl_atm & ~is_ack) | do_rev;
  assign wr_ok  = wr_en & ~full & ~ctl_clr;
  assign rd_try = rd_en & ~ctl_clr & ~commit & ~rewind;
  assign rd_ok  = rd_try & (rd_avail != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[PTR_W-1:0] & mask[PTR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      rmark <= '0;
    end else if (ctl_clr) begin
      wptr  <= '0;
      rptr  <= '0;
      rmark <= '0;
    end else begin
      if (wr_ok)  wptr  <= wptr + 1'b1;
      if (commit) rmark <= rptr;
      if (rewind)     rptr <= rmark;
      else if (rd_ok) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr[PTR_W-1:0] & mask[PTR_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_ack      <= 1'b0;
      stat_err      <= 1'b0;
      stat_underrun <= 1'b0;
      data_seq      <= 1'b0;
    end else if (ctl_clr) begin
      stat_ack      <= 1'b0;
      stat_err      <= 1'b0;
      stat_underrun <= 1'b0;
    end else begin
      if (eop_ok && !ctl_iso) begin
        stat_ack <= is_ack;
        stat_err <= ~is_ack;
        if (is_ack) data_seq <= ~data_seq;
      end
      if (rd_try && rd_avail == '0) stat_underrun <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_clr |-> byte_count <= cap); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !eop_valid && !ctl_clr && !ctl_adv && !ctl_we)
      |=> byte_count == $past(byte_count)); // R2
  AST_ACK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && eop_result == 2'b01 && ctl_atm && !ctl_iso && !ctl_clr && !wr_en)
      |=> byte_count == $past(rd_avail) && data_seq != $past(data_seq)); // R5
  AST_NACK_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && eop_result != 2'b01 && ctl_atm && !ctl_iso && !ctl_clr && !wr_en)
      |=> rd_avail == $past(byte_count) && stat_err); // R6
  AST_FLUSH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> empty && rd_avail == '0 && !stat_underrun && !stat_ack && !stat_err); // R8
  AST_FLUSH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> $stable(data_seq)); // R8
  AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr && !ctl_we) |=> !ctl_rdata[7]); // R8
  AST_MANUAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_adv || ctl_rev) && ctl_atm && !eop_valid && !wr_en && !rd_en && !ctl_clr)
      |=> byte_count == $past(byte_count) && rd_avail == $past(rd_avail)); // R11
  AST_ISO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_iso |-> ctl_atm); // R12

endmodule

// File: tb/txpkt_buf_tb.sv
module txpkt_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 10;

  logic clk = 0, rst_n = 0, feat_en = 1;
  logic ctl_we = 0; logic [7:0] ctl_wdata = 0; logic [7:0] ctl_rdata;
  logic wr_en = 0; logic [7:0] wr_data = 0;
  logic rd_en = 0; logic [7:0] rd_data;
  logic eop_valid = 0; logic [1:0] eop_result = 0;
  logic [PW:0] byte_count, rd_avail;
  logic empty, full, stat_ack, stat_err, stat_underrun, data_seq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic exp_seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txpkt_buf u_dut (.clk, .rst_n, .feat_en, .ctl_we, .ctl_wdata, .ctl_rdata,
    .wr_en, .wr_data, .rd_en, .rd_data, .eop_valid, .eop_result,
    .byte_count, .rd_avail, .empty, .full, .stat_ack, .stat_err,
    .stat_underrun, .data_seq);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ctl_write(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0; tick();
  endtask

  task automatic push(logic [7:0] b);
    wr_en = 1; wr_data = b; tick(); wr_en = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    rd_en = 1; tick(); rd_en = 0; b = rd_data;
  endtask

  task automatic eop(logic [1:0] r);
    eop_valid = 1; eop_result = r; tick(); eop_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_rdata, 8'h04);
    chk("R1 count", byte_count, 0);
    chk("R1 avail", rd_avail, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 status", {stat_ack, stat_err, stat_underrun, data_seq}, 0);
  endtask

  task automatic fill_check(string req, logic [7:0] ctl, int cap);
    ctl_write(ctl);
    for (int i = 0; i < cap + 3; i++) push(8'(i));
    chk(req, byte_count, cap);
    chk(req, full, 1);
  endtask

  task automatic t_noniso_cap();
    fill_check("R2 size0", 8'h84, 16);
    fill_check("R2 size1", 8'hA4, 64);
    fill_check("R2 size2", 8'hC4, 8);
    fill_check("R2 size3", 8'hE4, 32);
  endtask

  task automatic t_feat();
    feat_en = 0;
    fill_check("R3 size2", 8'hC4, 64);
    fill_check("R3 size3", 8'hE4, 64);
    fill_check("R3 size0", 8'h84, 16);
    feat_en = 1;
  endtask

  task automatic t_iso();
    logic [7:0] b;
    fill_check("R4 iso0", 8'h8C, 64);
    fill_check("R4 iso1", 8'hAC, 256);
    fill_check("R4 iso2", 8'hCC, 512);
    fill_check("R4 iso3", 8'hEC, 1024);
    ctl_write(8'hAC);
    for (int i = 0; i < 5; i++) push(8'(i));
    for (int i = 0; i < 5; i++) pop(b);
    eop(2'b10);
    chk("R7 commit count", byte_count, 0);
    chk("R7 seq kept", data_seq, exp_seq);
    chk("R7 status kept", {stat_ack, stat_err}, 0);
  endtask

  task automatic t_ack();
    logic [7:0] b;
    ctl_write(8'hA4);
    for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
    for (int i = 0; i < 4; i++) begin
      pop(b); chk("R5 data", b, 8'hA0 + i);
    end
    chk("R5 count before", byte_count, 4);
    eop(2'b01); exp_seq = ~exp_seq;
    chk("R5 count", byte_count, 0);
    chk("R5 empty", empty, 1);
    chk("R5 ack/err", {stat_ack, stat_err}, 2'b10);
    chk("R5 seq", data_seq, exp_seq);
  endtask

  task automatic t_nack();
    logic [7:0] b;
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i));
    for (int i = 0; i < 3; i++) pop(b);
    eop(2'b10);
    chk("R6 count", byte_count, 3);
    chk("R6 avail", rd_avail, 3);
    chk("R6 ack/err", {stat_ack, stat_err}, 2'b01);
    chk("R6 seq", data_seq, exp_seq);
    for (int i = 0; i < 3; i++) begin
      pop(b); chk("R6 replay", b, 8'h30 + i);
    end
    eop(2'b00);
    chk("R6 nohs avail", rd_avail, 3);
    chk("R6 nohs err", stat_err, 1);
  endtask

  task automatic t_flush();
    logic [7:0] b;
    ctl_we = 1; ctl_wdata = 8'hA4; tick(); ctl_we = 0;
    chk("R8 bit7 high", ctl_rdata[7], 1);
    tick();
    chk("R8 bit7 low", ctl_rdata[7], 0);
    chk("R8 count", byte_count, 0);
    chk("R8 avail", rd_avail, 0);
    chk("R8 empty", empty, 1);
    chk("R8 status", {stat_ack, stat_err, stat_underrun}, 0);
    chk("R8 seq kept", data_seq, exp_seq);
    push(8'h77); pop(b);
    chk("R8 restart", b, 8'h77);
  endtask

  task automatic t_manual();
    logic [7:0] b;
    ctl_write(8'hA0);
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    pop(b); pop(b);
    eop(2'b01); exp_seq = ~exp_seq;
    chk("R14 count", byte_count, 3);
    chk("R14 avail", rd_avail, 1);
    chk("R14 seq", data_seq, exp_seq);
    ctl_write(8'h21);
    chk("R10 avail", rd_avail, 3);
    chk("R10 selfclr", ctl_rdata, 8'h20);
    for (int i = 0; i < 3; i++) begin
      pop(b); chk("R10 replay", b, 8'h10 + i);
    end
    ctl_write(8'h22);
    chk("R9 count", byte_count, 0);
    chk("R9 selfclr", ctl_rdata, 8'h20);
    push(1); push(2); pop(b); pop(b);
    ctl_write(8'h23);
    chk("R11 both count", byte_count, 2);
    chk("R11 both avail", rd_avail, 0);
    chk("R11 both selfclr", ctl_rdata, 8'h20);
    ctl_write(8'h24);
    ctl_write(8'h26);
    chk("R11 auto adv", byte_count, 2);
    ctl_write(8'h25);
    chk("R11 auto rev", rd_avail, 0);
    chk("R11 auto selfclr", ctl_rdata, 8'h24);
  endtask

  task automatic t_ctlbits();
    ctl_write(8'h80);
    ctl_write(8'h18);
    chk("R12 iso forces auto", ctl_rdata, 8'h0C);
    ctl_write(8'h10);
    chk("R12 bit4", ctl_rdata[4], 0);
  endtask

  task automatic t_underrun();
    logic [7:0] b;
    ctl_write(8'hA4);
    push(8'h5A); pop(b);
    chk("R13 data", b, 8'h5A);
    chk("R13 no flag", stat_underrun, 0);
    pop(b);
    chk("R13 held", b, 8'h5A);
    chk("R13 flag", stat_underrun, 1);
    ctl_write(8'hA4);
    chk("R13 flush clears", stat_underrun, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; tick();
    t_reset();
    t_noniso_cap();
    t_feat();
    t_iso();
    t_ack();
    t_nack();
    t_flush();
    t_manual();
    t_ctlbits();
    t_underrun();
    finish_run();
  end
endmodule